// File: doc/BRIEF.md
# Display Link Lane Calculator

This block works out how many serial lanes a display link needs to carry a requested video mode. A start pulse captures a colour-depth code, the pixel clock in kHz and the link symbol frequency in MHz. The block decodes the colour depth into bits per pixel and applies a 5 % spread-spectrum margin to the raw pixel bit rate. It then divides, rounding up, by the payload capacity of one lane. The lane count, the bits per pixel and an error flag are reported together with a one-cycle done strobe.

Each line octet is sent as 10 line bits, so one lane carries `link_mhz * 1000 / 10` payload octets per millisecond-unit, which is `link_mhz * 800` kbit/s of payload. The margin is applied as `floor(pclk_khz * bpp * 21 / 20)` before the ceiling division. Both divisions run one after the other on a single restoring divider that produces one quotient bit per cycle.

The block has no data stream, so there is no valid/ready pair. The control handshake is plain. `start` is accepted only in a cycle where `busy` is low, and a cycle with `done` high counts as such a cycle. There is no back-pressure on the results: they stay on the outputs until the next `done`.

Top module: `link_lane_calc`

## Requirements
- R1: Colour-depth code 0 gives 24 bits per pixel, code 1 gives 30, code 2 gives 18 and code 3 gives 36.
- R2: Codes 4 to 7 are illegal. They report bpp = 0, lanes = 0 and err = 1, with a done pulse, and no division takes place.
- R3: For a legal code and a non-zero link frequency, lanes = ceil(B / (link_mhz * 800)) with B = floor(pclk_khz * bpp * 21 / 20). A zero pixel clock therefore gives 0 lanes and no error.
- R4: The margin quotient B is truncated before the ceiling division. For example, code 0 with pclk 127 and link 1 gives exactly 4 lanes and no error.
- R5: A lane count above MAX_LANES (4) sets err. The lanes output then shows the count, saturated at 2^LANE_W-1 (15).
- R6: A link frequency of 0 reports err = 1, lanes = 0 and the decoded bpp. The divider is never started with a zero divisor.
- R7: done is high for exactly one cycle per accepted start. bpp, lanes and err change only in the cycle where done is high, and they hold otherwise.
- R8: A start pulse while busy is high has no effect. The running calculation completes with its own inputs, and no extra done follows.
- R9: A start asserted in the cycle where done is high is accepted as a new calculation.
- R10: After reset, busy, done, err, bpp and lanes are 0. busy rises in the cycle after an accepted start, is low while done is high, and done arrives within 2*DIV_W+8 cycles of the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calculation (taken when busy is low) |
| depth_code | input | 3 | Colour-depth code |
| pclk_khz | input | PCLK_W (20) | Pixel clock in kHz |
| link_mhz | input | FREQ_W (12) | Link symbol frequency in MHz |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Illegal depth, zero link rate or too many lanes |
| bpp | output | 6 | Decoded bits per pixel |
| lanes | output | LANE_W (4) | Lane count, saturated |

## Verification
The done strobe of one calculation can coincide with the acceptance of the next start, because the cycle that carries done is already idle. The bench waits for done and raises start in that very cycle. It then requires three things: done drops on the next edge, busy rises, and the first results stay visible until the second done delivers the new ones. A second overlap is a start that arrives while the divider is running. The bench injects one with different inputs and judges it by the first result alone, followed by a long quiet window with no further done.

// File: rtl/lanecalc_pkg.sv
package lanecalc_pkg;

  localparam int LC_CODE_W = 3;
  localparam int LC_BPP_W  = 6;

  // colour-depth codes (component depth -> code)
  localparam logic [LC_CODE_W-1:0] LC_DEPTH8  = 3'd0;
  localparam logic [LC_CODE_W-1:0] LC_DEPTH10 = 3'd1;
  localparam logic [LC_CODE_W-1:0] LC_DEPTH6  = 3'd2;
  localparam logic [LC_CODE_W-1:0] LC_DEPTH12 = 3'd3;

  // margin ratio and line coding factor
  localparam int LC_MARGIN_NUM = 21;
  localparam int LC_MARGIN_DEN = 20;
  localparam int LC_LANE_KBPS_PER_MHZ = 800; // 1000/10 octets * 8 bits

  typedef enum logic [2:0] {
    LC_IDLE,
    LC_GO_MARGIN,
    LC_WAIT_MARGIN,
    LC_GO_LANES,
    LC_WAIT_LANES,
    LC_FINISH
  } lc_state_t;

endpackage

// File: rtl/lanecalc_depth_decode.sv
module lanecalc_depth_decode
  import lanecalc_pkg::*;
(
  input  logic [LC_CODE_W-1:0] code,
  output logic [LC_BPP_W-1:0]  bits_pp,
  output logic                 legal
);

  always_comb begin
    legal   = 1'b1;
    bits_pp = '0;
    unique case (code)
      LC_DEPTH8:  bits_pp = LC_BPP_W'(24);
      LC_DEPTH10: bits_pp = LC_BPP_W'(30);
      LC_DEPTH6:  bits_pp = LC_BPP_W'(18);
      LC_DEPTH12: bits_pp = LC_BPP_W'(36);
      default:    legal   = 1'b0;
    endcase
  end

endmodule

// File: rtl/lanecalc_divider.sv
module lanecalc_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fin,
  output logic [W-1:0] quotient
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] step_q;
  logic          run_q;
  logic [W:0]    rem_sh, trial;

  // shift in next dividend bit, trial subtract
  assign rem_sh = {rem_q, quo_q[W-1]};
  assign trial  = rem_sh - {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      step_q <= '0;
      run_q  <= 1'b0;
      fin    <= 1'b0;
    end else if (go) begin
      rem_q  <= '0;
      quo_q  <= dividend;
      dvs_q  <= divisor;
      step_q <= '0;
      run_q  <= 1'b1;
      fin    <= 1'b0;
    end else if (run_q) begin
      if (!trial[W]) begin
        rem_q <= trial[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= rem_sh[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
      step_q <= step_q + 1'b1;
      if (step_q == CW'(W-1)) begin
        run_q <= 1'b0;
        fin   <= 1'b1;
      end
    end else begin
      fin <= 1'b0;
    end
  end

  assign quotient = quo_q;

endmodule

// File: rtl/link_lane_calc.sv
module link_lane_calc
  import lanecalc_pkg::*;
#(
  parameter int PCLK_W    = 20,
  parameter int FREQ_W    = 12,
  parameter int LANE_W    = 4,
  parameter int MAX_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [2:0]           depth_code,
  input  logic [PCLK_W-1:0]    pclk_khz,
  input  logic [FREQ_W-1:0]    link_mhz,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic [5:0]           bpp,
  output logic [LANE_W-1:0]    lanes
);

  localparam int DIV_W    = PCLK_W + LC_BPP_W + 6;
  localparam int LANE_TOP = (1 << LANE_W) - 1;

  lc_state_t state_q;

  logic [LC_BPP_W-1:0] dec_bpp;
  logic                dec_legal;

  logic [DIV_W-1:0] prod_q, bw8_q, num_q;
  logic [LC_BPP_W-1:0] pend_bpp;
  logic [LANE_W-1:0]   pend_lanes;
  logic                pend_err;

  logic             dv_go, dv_fin;
  logic [DIV_W-1:0] dv_dividend, dv_divisor, dv_quo;

  lanecalc_depth_decode u_dec (
    .code    (depth_code),
    .bits_pp (dec_bpp),
    .legal   (dec_legal)
  );

  lanecalc_divider #(.W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (dv_go),
    .dividend (dv_dividend),
    .divisor  (dv_divisor),
    .fin      (dv_fin),
    .quotient (dv_quo)
  );

  // operand steering for the shared divider
  always_comb begin
    dv_go       = (state_q == LC_GO_MARGIN) || (state_q == LC_GO_LANES);
    dv_dividend = (state_q == LC_GO_MARGIN) ? prod_q : num_q;
    dv_divisor  = (state_q == LC_GO_MARGIN) ? DIV_W'(LC_MARGIN_DEN) : bw8_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= LC_IDLE;
      prod_q     <= '0;
      bw8_q      <= '0;
      num_q      <= '0;
      pend_bpp   <= '0;
      pend_lanes <= '0;
      pend_err   <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      bpp        <= '0;
      lanes      <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        LC_IDLE: begin
          if (start) begin
            pend_lanes <= '0;
            if (!dec_legal) begin
              pend_bpp <= '0;
              pend_err <= 1'b1;
              state_q  <= LC_FINISH;
            end else if (link_mhz == '0) begin
              pend_bpp <= dec_bpp;
              pend_err <= 1'b1;
              state_q  <= LC_FINISH;
            end else begin
              pend_bpp <= dec_bpp;
              pend_err <= 1'b0;
              prod_q   <= DIV_W'(pclk_khz) * DIV_W'(dec_bpp) * DIV_W'(LC_MARGIN_NUM);
              bw8_q    <= DIV_W'(link_mhz) * DIV_W'(LC_LANE_KBPS_PER_MHZ);
              state_q  <= LC_GO_MARGIN;
            end
          end
        end
        LC_GO_MARGIN: state_q <= LC_WAIT_MARGIN;
        LC_WAIT_MARGIN: begin
          if (dv_fin) begin
            num_q   <= dv_quo + bw8_q - DIV_W'(1);
            state_q <= LC_GO_LANES;
          end
        end
        LC_GO_LANES: state_q <= LC_WAIT_LANES;
        LC_WAIT_LANES: begin
          if (dv_fin) begin
            pend_err   <= (dv_quo > DIV_W'(MAX_LANES));
            pend_lanes <= (dv_quo > DIV_W'(LANE_TOP)) ? LANE_W'(LANE_TOP)
                                                       : dv_quo[LANE_W-1:0];
            state_q    <= LC_FINISH;
          end
        end
        LC_FINISH: begin
          bpp     <= pend_bpp;
          lanes   <= pend_lanes;
          err     <= pend_err;
          done    <= 1'b1;
          state_q <= LC_IDLE;
        end
        default: state_q <= LC_IDLE;
      endcase
    end
  end

  assign busy = (state_q != LC_IDLE);

endmodule

// File: rtl/lanecalc_checker.sv
module lanecalc_checker #(
  parameter int LANE_W    = 4,
  parameter int MAX_LANES = 4,
  parameter int DIV_W     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [5:0]        bpp,
  input logic [LANE_W-1:0] lanes,
  input logic              dv_go,
  input logic [DIV_W-1:0]  dv_divisor
);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(lanes) && $stable(bpp) && $stable(err)));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_no_zero_divisor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dv_go |-> (dv_divisor != '0));

  assert_lane_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (lanes <= LANE_W'(MAX_LANES)));

  assert_bad_depth_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bpp == '0) |-> (err && lanes == '0));

endmodule

bind link_lane_calc lanecalc_checker #(
  .LANE_W    (LANE_W),
  .MAX_LANES (MAX_LANES),
  .DIV_W     (DIV_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .bpp        (bpp),
  .lanes      (lanes),
  .dv_go      (dv_go),
  .dv_divisor (dv_divisor)
);

// File: tb/sim_link_lane_calc.sv
`timescale 1ns/1ps
module sim_link_lane_calc;

  localparam int PCLK_W = 20;
  localparam int FREQ_W = 12;
  localparam int LANE_W = 4;
  localparam int MAXL   = 4;
  localparam int DIV_W  = PCLK_W + 6 + 6;
  localparam int LAT_MAX = 2 * DIV_W + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] depth_code = '0;
  logic [PCLK_W-1:0] pclk_khz = '0;
  logic [FREQ_W-1:0] link_mhz = '0;
  logic busy, done, err;
  logic [5:0] bpp;
  logic [LANE_W-1:0] lanes;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk; // 125 MHz

  link_lane_calc #(.PCLK_W(PCLK_W), .FREQ_W(FREQ_W), .LANE_W(LANE_W), .MAX_LANES(MAXL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .depth_code(depth_code),
    .pclk_khz(pclk_khz), .link_mhz(link_mhz), .busy(busy), .done(done),
    .err(err), .bpp(bpp), .lanes(lanes)
  );

  task automatic summary_and_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, cycles %0d expected below 150000", cyc);
      summary_and_end();
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_bpp(input int code);
    case (code)
      0: return 24;
      1: return 30;
      2: return 18;
      3: return 36;
      default: return 0;
    endcase
  endfunction

  function automatic longint exp_raw_lanes(input int code, input longint pc, input longint f);
    longint b, w;
    b = (pc * exp_bpp(code) * 21) / 20;
    w = f * 800;
    return (b + w - 1) / w;
  endfunction

  task automatic launch(input int code, input int pc, input int f);
    @(negedge clk);
    depth_code = 3'(code);
    pclk_khz = PCLK_W'(pc);
    link_mhz = FREQ_W'(f);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < LAT_MAX + 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_result(input int code, input int pc, input int f, input string req);
    longint raw;
    int e_bpp, e_lanes;
    bit e_err;
    e_bpp = exp_bpp(code);
    if (e_bpp == 0) begin
      e_lanes = 0; e_err = 1'b1;
    end else if (f == 0) begin
      e_lanes = 0; e_err = 1'b1;
    end else begin
      raw = exp_raw_lanes(code, pc, f);
      e_lanes = (raw > 15) ? 15 : int'(raw);
      e_err = (raw > MAXL);
    end
    chk(bpp == 6'(e_bpp), {req, " bpp"}, bpp, e_bpp);
    chk(lanes == LANE_W'(e_lanes), {req, " lanes"}, lanes, e_lanes);
    chk(err == e_err, {req, " err"}, err, e_err);
  endtask

  task automatic run_one(input int code, input int pc, input int f, input string req);
    int lat;
    launch(code, pc, f);
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
    wait_done(lat);
    chk(done == 1'b1 && lat <= LAT_MAX, "R10 done latency", lat, LAT_MAX);
    chk(busy == 1'b0, "R10 busy low at done", busy, 0);
    check_result(code, pc, f, req);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", done, 0);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0, "R10 reset control", {busy, done}, 0);
    chk(err == 0 && bpp == 0 && lanes == 0, "R10 reset results", {err, bpp, lanes}, 0);
  endtask

  task automatic t_decode(); // R1, R3
    for (int c = 0; c < 4; c++) begin
      run_one(c, 148500, 2700, "R1");
      run_one(c, 297000, 1620, "R3");
    end
    run_one(1, 65000, 2700, "R3");
    run_one(0, 0, 2700, "R3 zero pixel clock");
  endtask

  task automatic t_illegal(); // R2
    for (int c = 4; c < 8; c++) run_one(c, 148500, 2700, "R2");
  endtask

  task automatic t_limits(); // R4, R5
    run_one(0, 127, 1, "R4 truncated margin");
    chk(lanes == 4 && err == 0, "R4 exact four lanes", lanes, 4);
    run_one(0, 128, 1, "R5 five lanes");
    chk(err == 1 && lanes == 5, "R5 five lanes flagged", lanes, 5);
    run_one(3, 100000, 1, "R5 saturated");
    chk(lanes == 15, "R5 saturation", lanes, 15);
  endtask

  task automatic t_zero_link(); // R6
    run_one(2, 148500, 0, "R6");
    run_one(3, 0, 0, "R6 all zero");
  endtask

  task automatic t_busy_ignore(); // R8
    int lat;
    int extra = 0;
    launch(0, 148500, 2700);
    repeat (5) @(negedge clk);
    depth_code = 3'd5; pclk_khz = '1; link_mhz = FREQ_W'(1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    chk(done == 1'b1, "R8 first run completes", done, 1);
    check_result(0, 148500, 2700, "R8");
    repeat (LAT_MAX + 10) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, "R8 no extra done", extra, 0);
  endtask

  task automatic t_back_to_back(); // R9, R7
    int lat;
    launch(3, 148500, 2700);
    wait_done(lat);
    check_result(3, 148500, 2700, "R9 first");
    depth_code = 3'd2; pclk_khz = PCLK_W'(25175); link_mhz = FREQ_W'(2700);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0 && busy == 1'b1, "R9 start in done cycle accepted", {done, busy}, 1);
    check_result(3, 148500, 2700, "R7 held during next run");
    wait_done(lat);
    chk(done == 1'b1, "R9 second done", done, 1);
    check_result(2, 25175, 2700, "R9 second");
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_illegal();
    t_limits();
    t_zero_link();
    t_busy_ignore();
    t_back_to_back();
    summary_and_end();
  end

endmodule